// File: doc/BRIEF.md
# Programmable Local Bus Chip-Select Timer

This block drives the active-low chip-select lines of a local peripheral bus that carries accesses bridged from a host bus. A host transaction is announced by a one-cycle initiator-ready strobe, together with the access direction and a 2-bit region select. The block fixes a reference cycle two clocks after the cycle in which it sees the strobe. It pulls the selected chip-select low and later releases it. The assert and release points are set in clock cycles from that reference. Reads and writes each have their own pair of 4-bit delays.

The four delays live in one 16-bit timing register with a write port. When an access is accepted, the block takes a copy of the register, so a write made while an access is running applies only to later accesses. One clock after chip-select is released, the block raises a one-cycle done flag. It accepts the next strobe only after that flag has gone.

Top module: `cs_timer`

## Requirements
- R1: Synchronous active-high reset sets every chip-select line high and the done flag low. The block is then idle.
- R2: Number cycles so that the strobe is sampled high in cycle 0. The reference cycle is cycle 2. Chip-select goes low in cycle 2+A, where A is the assertion delay of the access direction (0..15).
- R3: A read (direction input 1) takes its assertion delay from register bits 3:0 and its release delay from bits 7:4. Chip-select is low in cycles 2+A through 2+D-1, where D is the release delay.
- R4: A write (direction input 0) takes its assertion delay from bits 11:8 and its release delay from bits 15:12. The same window rule applies.
- R5: After reset the register reads as 16'h3030. Read and write assertion delays are 0 and both release delays are 3, so chip-select is low in cycles 2, 3 and 4.
- R6: Only the line whose index equals the region select goes low. The other three lines stay high throughout.
- R7: When the release delay is less than or equal to the assertion delay, chip-select is low for exactly one cycle, cycle 2+A.
- R8: The done flag is high for exactly one cycle, the cycle after the first high cycle of chip-select. For a window whose last low cycle is L, done is high in cycle L+2.
- R9: A strobe that arrives while an access is running, including in the done cycle, is ignored. No chip-select or done activity follows from it.
- R10: A register write takes effect from the next accepted access. A write made in the same cycle as the accepted strobe does not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irdy_i | input | 1 | Host initiator-ready strobe, one cycle per access |
| is_read_i | input | 1 | Access direction, 1 = read, 0 = write |
| region_i | input | 2 | Decoded region; selects the chip-select line |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_wdata_i | input | 16 | Timing register write data |
| cs_n_o | output | 4 | Chip-select lines, active low |
| done_o | output | 1 | One-cycle access completion flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a timing register write and the strobe that starts an access. The bench drives both in one cycle and expects the running access to keep the old delays and the next access to use the new ones. The second pair is the done cycle and a fresh strobe. The bench places a strobe in that exact cycle and in a mid-window cycle. It then watches enough following cycles to confirm that no second chip-select window or done pulse appears. Full sweeps over every read and write delay pair, with expected windows worked out arithmetically, cover the equal and inverted delay corners.

// File: rtl/cs_timer_pkg.sv
package cs_timer_pkg;

    localparam int unsigned FIELD_W = 4;
    localparam int unsigned CFG_W   = 4 * FIELD_W;
    localparam int unsigned REF_DLY = 2;
    localparam int unsigned END_W   = FIELD_W + 1;
    localparam int unsigned CNT_W   = $clog2(REF_DLY + (1 << FIELD_W) + 2) + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] wr_release;
        logic [FIELD_W-1:0] wr_assert;
        logic [FIELD_W-1:0] rd_release;
        logic [FIELD_W-1:0] rd_assert;
    } timing_t;

    localparam timing_t TIMING_RESET = '{
        wr_release: FIELD_W'(3),
        wr_assert:  FIELD_W'(0),
        rd_release: FIELD_W'(3),
        rd_assert:  FIELD_W'(0)
    };

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_DONE   = 2'd2
    } phase_t;

    function automatic logic [END_W-1:0] window_end(
        input logic [FIELD_W-1:0] asrt,
        input logic [FIELD_W-1:0] rel
    );
        if (rel > asrt) window_end = END_W'(rel);
        else            window_end = END_W'(asrt) + END_W'(1);
    endfunction

endpackage

// File: rtl/cs_timing_regs.sv
module cs_timing_regs
    import cs_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output timing_t          cfg_o
);

    always_ff @(posedge clk) begin
        if (rst)       cfg_o <= TIMING_RESET;
        else if (we_i) cfg_o <= timing_t'(wdata_i);
    end

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import cs_timer_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irdy_i,
    input  logic             is_read_i,
    input  logic [SEL_W-1:0] region_i,
    input  timing_t          cfg_i,
    output logic             window_o,
    output logic [SEL_W-1:0] region_o,
    output logic             done_o
);

    phase_t             phase;
    logic [CNT_W-1:0]   tick;
    logic [FIELD_W-1:0] lat_assert;
    logic [END_W-1:0]   lat_end;
    logic [CNT_W-1:0]   win_open;
    logic [CNT_W-1:0]   win_close;

    assign win_open  = CNT_W'(REF_DLY) + CNT_W'(lat_assert);
    assign win_close = CNT_W'(REF_DLY) + CNT_W'(lat_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            tick       <= '0;
            lat_assert <= '0;
            lat_end    <= '0;
            region_o   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (irdy_i) begin
                        phase    <= PH_ACTIVE;
                        tick     <= CNT_W'(1);
                        region_o <= region_i;
                        if (is_read_i) begin
                            lat_assert <= cfg_i.rd_assert;
                            lat_end    <= window_end(cfg_i.rd_assert, cfg_i.rd_release);
                        end else begin
                            lat_assert <= cfg_i.wr_assert;
                            lat_end    <= window_end(cfg_i.wr_assert, cfg_i.wr_release);
                        end
                    end
                end
                PH_ACTIVE: begin
                    if (tick == win_close) phase <= PH_DONE;
                    else                   tick  <= tick + CNT_W'(1);
                end
                PH_DONE:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign window_o = (phase == PH_ACTIVE) && (tick >= win_open) && (tick < win_close);
    assign done_o   = (phase == PH_DONE);

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R8: chip-select window is closed while done is high
    assert_done_after_release_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !window_o);
    // R9: strobe during done is not accepted
    assert_no_accept_in_done_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && irdy_i) |=> (phase == PH_IDLE));
    // R2: accepted strobe starts counting at cycle 1
    assert_accept_start_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && irdy_i) |=> (phase == PH_ACTIVE && tick == CNT_W'(1) && !window_o));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              window_i,
    input  logic [SEL_W-1:0]  region_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs_n_o[g] = !(window_i && (region_i == SEL_W'(g)));
    end

    // R6: at most one line low
    assert_single_line_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_o));
    // R6: a low line always belongs to an open window
    assert_low_needs_window_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_n_o != '1) |-> window_i);

endmodule

// File: rtl/cs_timer.sv
module cs_timer
    import cs_timer_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    localparam int unsigned SEL_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irdy_i,
    input  logic              is_read_i,
    input  logic [SEL_W-1:0]  region_i,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              done_o
);

    timing_t          cfg;
    logic             window;
    logic [SEL_W-1:0] region_q;

    cs_timing_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    cs_sequencer #(.SEL_W(SEL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .irdy_i    (irdy_i),
        .is_read_i (is_read_i),
        .region_i  (region_i),
        .cfg_i     (cfg),
        .window_o  (window),
        .region_o  (region_q),
        .done_o    (done_o)
    );

    cs_decoder #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .window_i (window),
        .region_i (region_q),
        .cs_n_o   (cs_n_o)
    );

    // R1: reset leaves every line high and done low
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (cs_n_o == '1 && !done_o));

endmodule

// File: tb/tb_cs_timer.sv
module tb_cs_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irdy_i = 1'b0;
    logic        is_read_i = 1'b0;
    logic [1:0]  region_i = 2'd0;
    logic        cfg_we_i = 1'b0;
    logic [15:0] cfg_wdata_i = 16'h0;
    logic [3:0]  cs_n_o;
    logic        done_o;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    cs_timer dut (
        .clk(clk), .rst(rst), .irdy_i(irdy_i), .is_read_i(is_read_i),
        .region_i(region_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .cs_n_o(cs_n_o), .done_o(done_o)
    );

    task automatic check(string tag, logic [3:0] exp_cs, logic exp_done, int k);
        n_checks++;
        if (cs_n_o !== exp_cs || done_o !== exp_done) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual cs_n=%b done=%b expected cs_n=%b done=%b",
                     tag, k, cs_n_o, done_o, exp_cs, exp_done);
        end
    endtask

    task automatic set_cfg(logic [15:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // One access; a and d are the delays the bench expects to apply.
    // inj_rdy: cycle index for a stray strobe (0 = none).
    // wr_k: cycle index for a register write of wr_val (0 = same cycle as strobe, -1 = none).
    task automatic access(string tag, logic rd, logic [1:0] rg, int a, int d,
                          int inj_rdy, int wr_k, logic [15:0] wr_val);
        int eff = (d > a) ? d : a + 1;
        int kmax = 2 * eff + 10;
        @(negedge clk);
        irdy_i = 1'b1;
        is_read_i = rd;
        region_i = rg;
        if (wr_k == 0) begin
            cfg_we_i = 1'b1;
            cfg_wdata_i = wr_val;
        end
        for (int k = 1; k <= kmax; k++) begin
            logic [3:0] e_cs;
            @(negedge clk);
            irdy_i = (k == inj_rdy);
            is_read_i = ~rd;
            region_i = rg + 2'd1;
            cfg_we_i = (k == wr_k);
            cfg_wdata_i = wr_val;
            e_cs = (k >= 2 + a && k < 2 + eff) ? ~(4'b0001 << rg) : 4'hF;
            check(tag, e_cs, (k == eff + 3), k);
        end
        irdy_i = 1'b0;
        cfg_we_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, stays idle without a strobe
        for (int k = 0; k < 4; k++) begin
            check("R1", 4'hF, 1'b0, k);
            @(negedge clk);
        end
        // R5: reset delays for both directions
        access("R5", 1'b1, 2'd0, 0, 3, 0, -1, 16'h0);
        access("R5", 1'b0, 2'd3, 0, 3, 0, -1, 16'h0);
        // R2: reference offset with assertion delay 5
        set_cfg(16'h0095);
        access("R2", 1'b1, 2'd1, 5, 9, 0, -1, 16'h0);
        // R6: each region drives only its own line
        set_cfg(16'h4141);
        for (int r = 0; r < 4; r++)
            access("R6", r[0], 2'(r), 1, 4, 0, -1, 16'h0);
        // R3 / R7: every read delay pair, write fields hold other values
        for (int a = 0; a < 16; a++)
            for (int d = 0; d < 16; d++) begin
                set_cfg({4'(15 - d), 4'(15 - a), 4'(d), 4'(a)});
                access((d > a) ? "R3" : "R7", 1'b1, 2'(a + d), a, d, 0, -1, 16'h0);
            end
        // R4 / R7: every write delay pair, read fields hold other values
        for (int a = 0; a < 16; a++)
            for (int d = 0; d < 16; d++) begin
                set_cfg({4'(d), 4'(a), 4'(a), 4'(d)});
                access((d > a) ? "R4" : "R7", 1'b0, 2'(a + 3 * d), a, d, 0, -1, 16'h0);
            end
        // R8: done follows a one-cycle window and a wide window
        set_cfg(16'h0077);
        access("R8", 1'b1, 2'd2, 7, 8, 0, -1, 16'h0);
        set_cfg(16'hF000);
        access("R8", 1'b0, 2'd1, 0, 15, 0, -1, 16'h0);
        // R9: stray strobe mid-window and in the done cycle
        set_cfg(16'h3131);
        access("R9", 1'b1, 2'd0, 1, 3, 3, -1, 16'h0);
        access("R9", 1'b0, 2'd3, 1, 3, 6, -1, 16'h0);
        access("R9", 1'b1, 2'd2, 1, 3, 1, -1, 16'h0);
        // R10: write in the accept cycle, then write mid-access
        access("R10", 1'b1, 2'd1, 1, 3, 0, 0, 16'h0062);
        access("R10", 1'b1, 2'd1, 2, 6, 0, 3, 16'h00A4);
        access("R10", 1'b1, 2'd2, 4, 10, 0, -1, 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule